// File: doc/BRIEF.md
# Serial-Bus Dual Wiper Position Controller

This block is the digital half of a pair of 256-position digital potentiometers. It is an I2C-compatible slave that keeps one 8-bit wiper position per potentiometer. For each potentiometer it also drives a one-hot 256-bit tap select, which closes exactly one switch of the resistor ladder. The bus lines are not used as clocks. Both lines are sampled on the internal system clock through two-flop synchronizers, and START, STOP and the SCL edges are found from the synchronized copies. The block pulls SDA low through a single open-drain enable.

A transaction begins with a START and an address byte. An instruction byte follows, and it selects one of three operations on one wiper:
- read the position;
- write a new position;
- enter a stepping mode.

In stepping mode byte framing stops. Each complete SCL high pulse moves the wiper one position, in the direction given by SDA, until STOP. The block carries no data stream, so it has no valid/ready interface and no back-pressure. All pins are plain control or level signals.

Top module: `dpot_wiper_ctrl`

## Requirements
- R1: After reset both wiper positions are 0x80, each tap select has only bit 128 set, and `sda_oe` is 0.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including in the middle of a byte, restarts address reception. A STOP returns the block to idle.
- R3: The address byte matches only when it equals {4'b0101, dev_addr}, sent MSB first. On a match the block acknowledges by driving `sda_oe`=1 during the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next START.
- R4: In the instruction byte, bits 7:4 hold the opcode and bits 3:1 must be 000. Bit 0 selects wiper 0 or wiper 1. Valid opcodes are 1001 (read), 1010 (write) and 0010 (step). Any other opcode, or nonzero bits 3:1, gets no acknowledge, changes no register, and the bus is ignored until the next START.
- R5: A write acknowledges the data byte and loads it into the selected wiper. The other wiper is left unchanged.
- R6: A read shifts out the selected wiper MSB first and releases SDA on the ninth clock. If the master acknowledges, the current value is sent again. If the master does not acknowledge, the block stops driving SDA.
- R7: In step mode, each SCL high pulse that ends with a falling SCL moves the selected wiper up by one if SDA was high at the rising edge, or down by one if it was low. The block gives no acknowledge in this mode. An SCL high pulse that is closed by STOP moves nothing.
- R8: Stepping saturates at 255 going up and at 0 going down, with no wrap-around.
- R9: Each tap select is one-hot, with the bit at the wiper's value set. It follows a wiper change one clock later.
- R10: `sda_oe` rises only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| dev_addr | input | 4 | Static address strap compared with the address byte low nibble |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| wiper0 | output | 8 | Position of wiper 0 |
| wiper1 | output | 8 | Position of wiper 1 |
| tap0 | output | 256 | One-hot tap select for potentiometer 0 |
| tap1 | output | 256 | One-hot tap select for potentiometer 1 |

## Verification
The bench drives stepping into both rails:
- A design that wraps would show 0x00 after 255, or 0xFF after 0.

It ends a stepping sequence with STOP:
- A design that steps on the rising SCL edge would take one extra decrement from the high pulse that precedes STOP.

It checks the error and restart paths:
- A repeated START in the middle of an address, a wrong address and an illegal instruction are all sent. A design that kept stale bit counts or state would acknowledge the wrong byte or corrupt a wiper.

It checks read behaviour:
- A read with a master acknowledge must resend the same value.
- A read with no acknowledge must leave SDA released.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam int WIPER_W = 8;
  localparam int TAP_N   = 1 << WIPER_W;
  localparam logic [3:0] DEV_ID  = 4'b0101;
  localparam logic [3:0] OP_RD   = 4'b1001;
  localparam logic [3:0] OP_WR   = 4'b1010;
  localparam logic [3:0] OP_STEP = 4'b0010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_RDATA, ST_STEP, ST_HOLD
  } bus_st_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '1;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         step_en,
  input  logic         sel,
  input  logic         up,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] wiper0,
  output logic [W-1:0] wiper1
);
  localparam logic [W-1:0] MID = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] pos [2];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos[c] <= MID;
      end else if (sel == c[0]) begin
        if (wr_en) begin
          pos[c] <= wdata;
        end else if (step_en) begin
          if (up && pos[c] != TOP)              pos[c] <= pos[c] + W'(1);
          else if (!up && pos[c] != '0)         pos[c] <= pos[c] - W'(1);
        end
      end
    end
  end

  assign wiper0 = pos[0];
  assign wiper1 = pos[1];
endmodule

// File: rtl/dpot_tap_decode.sv
module dpot_tap_decode #(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      val,
  output logic [(1<<W)-1:0] tap
);
  localparam int N   = 1 << W;
  localparam int MID = 1 << (W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap <= N'(1) << MID;
    else        tap <= N'(1) << val;
  end
endmodule

// File: rtl/dpot_bus_engine.sv
module dpot_bus_engine
  import dpot_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_s,
  input  logic               sda_s,
  input  logic [3:0]         dev_addr,
  input  logic [WIPER_W-1:0] cur0,
  input  logic [WIPER_W-1:0] cur1,
  output logic               sda_oe,
  output logic               wr_en,
  output logic               step_en,
  output logic               sel,
  output logic               step_up,
  output logic [WIPER_W-1:0] wr_data
);
  bus_st_e      state;
  logic [3:0]   cnt;
  logic [7:0]   shreg;
  logic [7:0]   txreg;
  logic [3:0]   op;
  logic         dir, mack, scl_q, sda_q;
  logic         scl_rise, scl_fall, start_c, stop_c, addr_hit, instr_ok;
  logic [7:0]   cur;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_hit = (shreg == {DEV_ID, dev_addr});
  assign instr_ok = (shreg[3:1] == 3'b000) &&
                    (shreg[7:4] == OP_RD || shreg[7:4] == OP_WR || shreg[7:4] == OP_STEP);
  assign cur      = sel ? cur1 : cur0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  txreg <= '0;  op <= '0;
      dir <= 1'b0;  mack <= 1'b0;  sda_oe <= 1'b0;  sel <= 1'b0;
      wr_en <= 1'b0;  step_en <= 1'b0;  step_up <= 1'b0;  wr_data <= '0;
    end else begin
      wr_en   <= 1'b0;
      step_en <= 1'b0;
      if (start_c) begin
        state <= ST_ADDR;  cnt <= '0;  sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= ST_IDLE;  cnt <= '0;  sda_oe <= 1'b0;
      end else if (scl_rise) begin
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
        shreg <= {shreg[6:0], sda_s};
        if (state == ST_RDATA && cnt == 4'd8) mack <= ~sda_s;
        if (state == ST_STEP) dir <= sda_s;
      end else if (scl_fall) begin
        case (state)
          ST_ADDR: begin
            if (cnt == 4'd8) begin
              if (addr_hit) sda_oe <= 1'b1;
              else          state  <= ST_HOLD;
            end else if (cnt == 4'd9) begin
              sda_oe <= 1'b0;  cnt <= '0;  state <= ST_INSTR;
            end
          end
          ST_INSTR: begin
            if (cnt == 4'd8) begin
              if (instr_ok) begin
                sda_oe <= 1'b1;  sel <= shreg[0];  op <= shreg[7:4];
              end else begin
                state <= ST_HOLD;
              end
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (op == OP_RD) begin
                state <= ST_RDATA;  txreg <= cur;  sda_oe <= ~cur[7];
              end else begin
                sda_oe <= 1'b0;
                state  <= (op == OP_WR) ? ST_WDATA : ST_STEP;
              end
            end
          end
          ST_WDATA: begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b1;  wr_en <= 1'b1;  wr_data <= shreg;
            end else if (cnt == 4'd9) begin
              sda_oe <= 1'b0;  state <= ST_HOLD;
            end
          end
          ST_RDATA: begin
            if (cnt >= 4'd1 && cnt <= 4'd7) begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end else if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
            end else if (cnt == 4'd9) begin
              cnt <= '0;
              if (mack) begin
                txreg <= cur;  sda_oe <= ~cur[7];
              end else begin
                state <= ST_HOLD;
              end
            end
          end
          ST_STEP: begin
            step_en <= 1'b1;  step_up <= dir;  cnt <= '0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_wiper_ctrl.sv
module dpot_wiper_ctrl
  import dpot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [3:0]         dev_addr,
  output logic               sda_oe,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1,
  output logic [TAP_N-1:0]   tap0,
  output logic [TAP_N-1:0]   tap1
);
  logic               scl_s, sda_s, wr_en, step_en, ctl_sel, step_up;
  logic [WIPER_W-1:0] wr_data;
  logic [WIPER_W-1:0] pos_v [2];
  logic [TAP_N-1:0]   tap_v [2];

  dpot_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  dpot_bus_engine u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .dev_addr(dev_addr),
    .cur0(wiper0), .cur1(wiper1), .sda_oe(sda_oe), .wr_en(wr_en),
    .step_en(step_en), .sel(ctl_sel), .step_up(step_up), .wr_data(wr_data)
  );

  dpot_wiper_bank #(.W(WIPER_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .step_en(step_en), .sel(ctl_sel),
    .up(step_up), .wdata(wr_data), .wiper0(wiper0), .wiper1(wiper1)
  );

  assign pos_v[0] = wiper0;
  assign pos_v[1] = wiper1;

  for (genvar c = 0; c < 2; c++) begin : g_tap
    dpot_tap_decode #(.W(WIPER_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .val(pos_v[c]), .tap(tap_v[c])
    );
  end

  assign tap0 = tap_v[0];
  assign tap1 = tap_v[1];
endmodule

// File: rtl/dpot_wiper_chk.sv
module dpot_wiper_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_s,
  input logic         sda_oe,
  input logic         step_en,
  input logic         wr_en,
  input logic         sel,
  input logic         up,
  input logic [7:0]   wiper0,
  input logic [7:0]   wiper1,
  input logic [255:0] tap0,
  input logic [255:0] tap1
);
  // R1
  reset_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper0 == 8'h80 && wiper1 == 8'h80 && !sda_oe));

  // R9
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap0) == 1 && $countones(tap1) == 1));

  // R9
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_n) |-> (tap0[$past(wiper0)] && tap1[$past(wiper1)]));

  // R8
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wr_en && !sel && up && wiper0 == 8'hFF) |=> wiper0 == 8'hFF);

  // R8
  sat_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wr_en && sel && !up && wiper1 == 8'h00) |=> wiper1 == 8'h00);

  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !wr_en && !sel && up && wiper0 != 8'hFF) |=> wiper0 == 8'($past(wiper0) + 8'd1));

  // R10
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind dpot_wiper_ctrl dpot_wiper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .step_en(step_en),
  .wr_en(wr_en), .sel(ctl_sel), .up(step_up), .wiper0(wiper0), .wiper1(wiper1),
  .tap0(tap0), .tap1(tap1)
);

// File: tb/test_dpot_wiper_ctrl.sv
`timescale 1ns/1ps
module test_dpot_wiper_ctrl;
  localparam int Q = 8;
  localparam logic [3:0] MY_ADDR = 4'hA;
  localparam logic [7:0] ABYTE = {4'b0101, MY_ADDR};

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, m_pull = 1'b0;
  logic sda_oe, sda_line;
  logic [7:0] wiper0, wiper1;
  logic [255:0] tap0, tap1;
  int tests = 0, fails = 0, oe_bad = 0;
  int exp_w [2];

  always #2 clk = ~clk;
  assign sda_line = ~(m_pull | sda_oe);

  dpot_wiper_ctrl i_dpot_wiper_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .dev_addr(MY_ADDR),
    .sda_oe(sda_oe), .wiper0(wiper0), .wiper1(wiper1), .tap0(tap0), .tap1(tap1)
  );

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe && !oe_prev && scl_m) oe_bad++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic bstart;
    m_pull = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); m_pull = 1'b1; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bstop;
    m_pull = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); m_pull = 1'b0; wq(2*Q);
  endtask

  task automatic sbit(input bit b);
    m_pull = ~b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
  endtask

  task automatic sbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    m_pull = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_line; wq(Q); scl_m = 1'b0;
  endtask

  task automatic rbyte(input bit mack, output logic [7:0] d);
    m_pull = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl_m = 1'b1; wq(Q); d = {d[6:0], sda_line}; wq(Q); scl_m = 1'b0;
    end
    sbit(~mack);
    m_pull = 1'b0;
  endtask

  function automatic int sat(input int v, input bit up);
    if (up) return (v == 255) ? 255 : v + 1;
    return (v == 0) ? 0 : v - 1;
  endfunction

  task automatic check_state(input string req);
    chk(wiper0 == exp_w[0], req, wiper0, exp_w[0]);
    chk(wiper1 == exp_w[1], req, wiper1, exp_w[1]);
    chk(tap0[exp_w[0]] && $countones(tap0) == 1, "R9", $countones(tap0), 1);
    chk(tap1[exp_w[1]] && $countones(tap1) == 1, "R9", $countones(tap1), 1);
  endtask

  task automatic do_write(input bit p, input logic [7:0] v);
    bit a1, a2, a3;
    bstart; sbyte(ABYTE, a1); sbyte({4'b1010, 3'b000, p}, a2); sbyte(v, a3); bstop;
    chk(a1 && a2 && a3, "R5", {a1, a2, a3}, 3'b111);
    exp_w[p] = v;
    check_state("R5");
  endtask

  task automatic do_read(input bit p, input int n);
    bit a1, a2; logic [7:0] d;
    bstart; sbyte(ABYTE, a1); sbyte({4'b1001, 3'b000, p}, a2);
    chk(a1 && a2, "R3", {a1, a2}, 2'b11);
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d == 8'(exp_w[p]), "R6", d, exp_w[p]);
    end
    chk(sda_oe == 1'b0, "R6", sda_oe, 0);
    bstop;
  endtask

  task automatic do_step(input bit p, input int n, input bit fixed_dir, input bit dir0);
    bit a1, a2, dir; int acks = 0;
    bstart; sbyte(ABYTE, a1); sbyte({4'b0010, 3'b000, p}, a2);
    chk(a1 && a2, "R4", {a1, a2}, 2'b11);
    for (int i = 0; i < n; i++) begin
      dir = fixed_dir ? dir0 : 1'($urandom_range(0, 1));
      m_pull = ~dir; wq(Q); scl_m = 1'b1; wq(Q);
      if (sda_oe) acks++;
      wq(Q); scl_m = 1'b0;
      exp_w[p] = sat(exp_w[p], dir);
    end
    bstop;
    chk(acks == 0, "R7", acks, 0);
    check_state("R7");
  endtask

  task automatic do_bad(input logic [7:0] ab, input logic [7:0] ib, input string req,
                        input bit exp_a1);
    bit a1, a2, a3;
    bstart; sbyte(ab, a1); sbyte(ib, a2); sbyte(8'h55, a3); bstop;
    chk(a1 == exp_a1 && !a2 && !a3, req, {a1, a2, a3}, {exp_a1, 2'b00});
    check_state(req);
  endtask

  initial begin
    logic [7:0] ab, ib;
    bit a1;
    void'($urandom(32'd4242));
    exp_w[0] = 128; exp_w[1] = 128;
    wq(10); rst_n = 1'b1; wq(4);
    chk(sda_oe == 1'b0, "R1", sda_oe, 0);
    check_state("R1");

    do_write(1'b0, 8'h3C);
    do_write(1'b1, 8'hC5);
    do_read(1'b0, 3);
    do_read(1'b1, 1);
    do_bad({4'b0101, MY_ADDR ^ 4'h3}, {4'b1010, 4'b0000}, "R3", 1'b0);
    do_bad({4'b0111, MY_ADDR}, {4'b1010, 4'b0000}, "R3", 1'b0);
    do_bad(ABYTE, 8'hB0, "R4", 1'b1);
    do_bad(ABYTE, 8'hA2, "R4", 1'b1);

    // R2: repeated START cuts an address byte short, then a full write follows
    bstart; sbit(1'b0); sbit(1'b1); sbit(1'b0);
    do_write(1'b1, 8'h11);
    // R2: repeated START right after an acknowledged address
    bstart; sbyte(ABYTE, a1);
    do_write(1'b0, 8'h77);

    // R8: rails
    do_write(1'b1, 8'hFD);
    do_step(1'b1, 5, 1'b1, 1'b1);
    chk(wiper1 == 8'hFF, "R8", wiper1, 8'hFF);
    do_write(1'b0, 8'h02);
    do_step(1'b0, 4, 1'b1, 1'b0);
    chk(wiper0 == 8'h00, "R8", wiper0, 8'h00);
    do_step(1'b1, 3, 1'b1, 1'b0);
    do_step(1'b0, 6, 1'b0, 1'b0);

    for (int t = 0; t < 40; t++) begin
      case ($urandom_range(0, 5))
        0, 1: do_write(1'($urandom_range(0, 1)), 8'($urandom));
        2:    do_read(1'($urandom_range(0, 1)), $urandom_range(1, 2));
        3:    do_step(1'($urandom_range(0, 1)), $urandom_range(0, 9), 1'b0, 1'b0);
        4: begin
          ab = 8'($urandom);
          if (ab == ABYTE) ab = ab ^ 8'h01;
          do_bad(ab, {4'b1010, 4'b0000}, "R3", 1'b0);
        end
        default: begin
          ib = 8'($urandom);
          if (ib[3:1] == 3'b000 && (ib[7:4] == 4'b1001 || ib[7:4] == 4'b1010 || ib[7:4] == 4'b0010))
            ib[2] = 1'b1;
          do_bad(ABYTE, ib, "R4", 1'b1);
        end
      endcase
    end

    chk(oe_bad == 0, "R10", oe_bad, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule